// File: doc/BRIEF.md
# Zero-Suppressing Multichannel Acquisition Sequencer

This block runs one acquisition cycle for eight time-measuring channels. A trigger pulse is taken only while the block is idle, the output FIFO has room and at least one channel is enabled. Taking it raises busy and advances a 12-bit event counter. In common-start mode the enabled channels get a start pulse and a time-out counter runs up to a programmed full-scale value before sampling. In common-stop mode the channels get a stop pulse and sampling begins at once.

Sampling is a request/acknowledge handshake with the analog front end. It delivers one 12-bit sample per channel. The upper eight bits of each sample are compared against an inclusive low/high window, and only enabled channels inside the window survive. When at least one channel survives, the block writes a header word to the FIFO. It then requests one conversion per surviving channel, lowest channel first, and writes one data word per conversion. When nothing survives, the FIFO is left untouched and the cycle ends at once. Busy also stays high while the FIFO is too full to take another event, and a mode bit chooses the fill level that blocks.

Top module: `acq_sequencer`

## Requirements
- R1: A trigger is accepted only when busy is low and at least one bit of `chan_en_i` is set. A trigger with no channel enabled leaves busy low and the event counter unchanged.
- R2: With `mode_stop_i` = 0, `tac_start_o` equals the enable mask for exactly the cycle after the accepting edge. `smp_req_o` then rises `full_scale_i`+1 cycles after busy rises.
- R3: Each accepted trigger adds one to the 12-bit event counter, which wraps from 4095 to 0. The header carries the value after the increment.
- R4: A trigger that arrives while busy is high is ignored and does not change the event counter.
- R5: A channel is converted only if it is enabled and `thr_lo_i` <= sample[11:4] <= `thr_hi_i`, with both bounds inclusive.
- R6: The header word is bit15 = 1, bits14..3 = event counter, bits2..0 = number of surviving channels minus one. It is the first word written for the event.
- R7: Each data word is bit15 = 0, bits14..12 = channel number, bits11..0 = `conv_data_i`. Data words follow the header in ascending channel order, one per surviving channel.
- R8: If no channel survives, nothing is written to the FIFO, and busy falls on the clock after the sample acknowledge.
- R9: With `fifo_full_mode_i` = 0, busy is high whenever `fifo_level_i` > 256. With `fifo_full_mode_i` = 1, busy is high whenever `fifo_level_i` >= 512. A trigger in either blocked state is ignored.
- R10: With `mode_stop_i` = 1, `tac_stop_o` pulses for one cycle after the accepting edge, and `smp_req_o` rises in that same cycle.
- R11: A synchronous reset clears the event counter, returns the sequencer to idle and drops busy and all requests, even in the middle of an event.
- R12: After the last data word of an event, busy falls on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Common trigger pulse |
| mode_stop_i | input | 1 | 0 = common start, 1 = common stop |
| chan_en_i | input | 8 | Per-channel enable |
| thr_lo_i | input | 8 | Inclusive lower window bound |
| thr_hi_i | input | 8 | Inclusive upper window bound |
| full_scale_i | input | 10 | Time-out limit in clock cycles (common start) |
| fifo_full_mode_i | input | 1 | 0 = block above half, 1 = block when full |
| fifo_level_i | input | 10 | Current FIFO occupancy in words |
| tac_start_o | output | 8 | Start pulse per enabled channel |
| tac_stop_o | output | 1 | Common stop pulse |
| smp_req_o | output | 1 | Sample request, held until acknowledged |
| smp_ack_i | input | 1 | Sample acknowledge; samples valid with it |
| smp_data_i | input | 96 | Eight 12-bit samples, channel n at bits 12n+11..12n |
| conv_req_o | output | 1 | Conversion request |
| conv_ch_o | output | 3 | Channel to convert |
| conv_ack_i | input | 1 | Conversion done; result valid with it |
| conv_data_i | input | 12 | Converted value |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 16 | FIFO write word |
| busy_o | output | 1 | Busy (active or FIFO blocked) |
| evt_cnt_o | output | 12 | Event counter |

## Verification
Busy and the start or stop pulse appear one clock after the edge that takes the trigger. The sample request follows full-scale plus one clocks later in common-start mode, and in that same clock in common-stop mode. FIFO-blocked busy follows the level input with no delay. The data words appear in the clock where each conversion acknowledge is present, and busy falls exactly one clock after the last write. The bench drives inputs on the falling edge and samples a few nanoseconds after it. It counts clocks between those sample points, so every timing check compares an exact clock count against the value computed from the programmed full scale.

// File: rtl/acq_pkg.sv
package acq_pkg;

    localparam int unsigned ACQ_NCH    = 8;
    localparam int unsigned ACQ_CH_W   = $clog2(ACQ_NCH);
    localparam int unsigned ACQ_SMP_W  = 12;
    localparam int unsigned ACQ_EVT_W  = 12;
    localparam int unsigned ACQ_WORD_W = 1 + ACQ_EVT_W + ACQ_CH_W;

    // Header and data word layouts; both span ACQ_WORD_W bits.
    typedef struct packed {
        logic                 is_hdr;
        logic [ACQ_EVT_W-1:0] evt;
        logic [ACQ_CH_W-1:0]  mult;
    } hdr_word_t;

    typedef struct packed {
        logic                 is_hdr;
        logic [ACQ_CH_W-1:0]  chan;
        logic [ACQ_SMP_W-1:0] value;
    } dat_word_t;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_ARM,
        SEQ_SAMPLE,
        SEQ_HEADER,
        SEQ_CONVERT
    } seq_state_e;

    // Index of the lowest set bit (zero when none set).
    function automatic logic [ACQ_CH_W-1:0] lowest_set(input logic [ACQ_NCH-1:0] m);
        logic [ACQ_CH_W-1:0] idx;
        idx = '0;
        for (int i = ACQ_NCH - 1; i >= 0; i--) begin
            if (m[i]) idx = ACQ_CH_W'(i);
        end
        return idx;
    endfunction

    function automatic logic [ACQ_CH_W:0] count_set(input logic [ACQ_NCH-1:0] m);
        logic [ACQ_CH_W:0] n;
        n = '0;
        for (int i = 0; i < ACQ_NCH; i++) begin
            n = n + {{ACQ_CH_W{1'b0}}, m[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/acq_window.sv
module acq_window #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned SMP_W = 12,
    parameter int unsigned THR_W = 8
) (
    input  logic [NCH*SMP_W-1:0] samples_i,
    input  logic [NCH-1:0]       en_i,
    input  logic [THR_W-1:0]     lo_i,
    input  logic [THR_W-1:0]     hi_i,
    output logic [NCH-1:0]       hit_o
);

    localparam int unsigned DROP = SMP_W - THR_W;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [THR_W-1:0] coarse;
        assign coarse   = samples_i[g*SMP_W + DROP +: THR_W];
        assign hit_o[g] = en_i[g] && (coarse >= lo_i) && (coarse <= hi_i);
    end

endmodule

// File: rtl/acq_timeout.sv
module acq_timeout #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            count_q <= '0;
        end else if (count_q != limit_i) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign done_o = run_i && (count_q == limit_i);

endmodule

// File: rtl/acq_fifo_guard.sv
module acq_fifo_guard #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned LVL_W = 10
) (
    input  logic [LVL_W-1:0] level_i,
    input  logic             full_mode_i,
    output logic             blocked_o
);

    localparam logic [LVL_W-1:0] FULL_MARK = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] HALF_MARK = LVL_W'(DEPTH / 2);

    assign blocked_o = full_mode_i ? (level_i >= FULL_MARK) : (level_i > HALF_MARK);

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_pkg::*;
#(
    parameter int unsigned THR_W      = 8,
    parameter int unsigned TO_W       = 10,
    parameter int unsigned FIFO_DEPTH = 512,
    parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH) + 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           trig_i,
    input  logic                           mode_stop_i,
    input  logic [ACQ_NCH-1:0]             chan_en_i,
    input  logic [THR_W-1:0]               thr_lo_i,
    input  logic [THR_W-1:0]               thr_hi_i,
    input  logic [TO_W-1:0]                full_scale_i,
    input  logic                           fifo_full_mode_i,
    input  logic [LVL_W-1:0]               fifo_level_i,
    output logic [ACQ_NCH-1:0]             tac_start_o,
    output logic                           tac_stop_o,
    output logic                           smp_req_o,
    input  logic                           smp_ack_i,
    input  logic [ACQ_NCH*ACQ_SMP_W-1:0]   smp_data_i,
    output logic                           conv_req_o,
    output logic [ACQ_CH_W-1:0]            conv_ch_o,
    input  logic                           conv_ack_i,
    input  logic [ACQ_SMP_W-1:0]           conv_data_i,
    output logic                           fifo_wr_o,
    output logic [ACQ_WORD_W-1:0]          fifo_data_o,
    output logic                           busy_o,
    output logic [ACQ_EVT_W-1:0]           evt_cnt_o
);

    localparam logic [ACQ_NCH-1:0]  ONE_HOT0 = {{(ACQ_NCH-1){1'b0}}, 1'b1};
    localparam logic [ACQ_CH_W:0]   CNT_ONE  = {{ACQ_CH_W{1'b0}}, 1'b1};

    seq_state_e            state_q;
    logic [ACQ_NCH-1:0]    en_q;
    logic [ACQ_NCH-1:0]    pend_q;
    logic [ACQ_EVT_W-1:0]  evt_q;
    logic [ACQ_CH_W-1:0]   mult_q;
    logic [ACQ_NCH-1:0]    start_q;
    logic                  stop_q;

    logic                  blocked;
    logic                  accept;
    logic                  tmo_done;
    logic [ACQ_NCH-1:0]    hit;
    logic [ACQ_CH_W:0]     hit_cnt;
    logic [ACQ_CH_W:0]     hit_cnt_m1;
    logic [ACQ_CH_W-1:0]   cur_ch;
    logic [ACQ_NCH-1:0]    pend_next;
    hdr_word_t             hdr_word;
    dat_word_t             dat_word;

    acq_fifo_guard #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_guard (
        .level_i     (fifo_level_i),
        .full_mode_i (fifo_full_mode_i),
        .blocked_o   (blocked)
    );

    acq_timeout #(.CNT_W(TO_W)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .run_i   (state_q == SEQ_ARM),
        .limit_i (full_scale_i),
        .done_o  (tmo_done)
    );

    acq_window #(.NCH(ACQ_NCH), .SMP_W(ACQ_SMP_W), .THR_W(THR_W)) u_win (
        .samples_i (smp_data_i),
        .en_i      (en_q),
        .lo_i      (thr_lo_i),
        .hi_i      (thr_hi_i),
        .hit_o     (hit)
    );

    always_comb begin
        accept     = trig_i && (state_q == SEQ_IDLE) && !blocked && (|chan_en_i);
        hit_cnt    = count_set(hit);
        hit_cnt_m1 = hit_cnt - CNT_ONE;
        cur_ch     = lowest_set(pend_q);
        pend_next  = pend_q & ~(ONE_HOT0 << cur_ch);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            en_q    <= '0;
            pend_q  <= '0;
            evt_q   <= '0;
            mult_q  <= '0;
            start_q <= '0;
            stop_q  <= 1'b0;
        end else begin
            start_q <= '0;
            stop_q  <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        evt_q <= evt_q + ACQ_EVT_W'(1);
                        en_q  <= chan_en_i;
                        if (mode_stop_i) begin
                            stop_q  <= 1'b1;
                            state_q <= SEQ_SAMPLE;
                        end else begin
                            start_q <= chan_en_i;
                            state_q <= SEQ_ARM;
                        end
                    end
                end
                SEQ_ARM: begin
                    if (tmo_done) state_q <= SEQ_SAMPLE;
                end
                SEQ_SAMPLE: begin
                    if (smp_ack_i) begin
                        pend_q  <= hit;
                        mult_q  <= hit_cnt_m1[ACQ_CH_W-1:0];
                        state_q <= (|hit) ? SEQ_HEADER : SEQ_IDLE;
                    end
                end
                SEQ_HEADER: begin
                    state_q <= SEQ_CONVERT;
                end
                SEQ_CONVERT: begin
                    if (conv_ack_i) begin
                        pend_q <= pend_next;
                        if (pend_next == '0) state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        hdr_word.is_hdr = 1'b1;
        hdr_word.evt    = evt_q;
        hdr_word.mult   = mult_q;
        dat_word.is_hdr = 1'b0;
        dat_word.chan   = cur_ch;
        dat_word.value  = conv_data_i;
    end

    assign tac_start_o = start_q;
    assign tac_stop_o  = stop_q;
    assign smp_req_o   = (state_q == SEQ_SAMPLE);
    assign conv_req_o  = (state_q == SEQ_CONVERT);
    assign conv_ch_o   = cur_ch;
    assign fifo_wr_o   = (state_q == SEQ_HEADER) || ((state_q == SEQ_CONVERT) && conv_ack_i);
    assign fifo_data_o = (state_q == SEQ_HEADER) ? ACQ_WORD_W'(hdr_word) : ACQ_WORD_W'(dat_word);
    assign busy_o      = (state_q != SEQ_IDLE) || blocked;
    assign evt_cnt_o   = evt_q;

endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk
    import acq_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 512,
    parameter int unsigned LVL_W      = 10
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  trig_i,
    input logic [ACQ_NCH-1:0]    chan_en_i,
    input logic                  fifo_full_mode_i,
    input logic [LVL_W-1:0]      fifo_level_i,
    input logic [ACQ_NCH-1:0]    tac_start_o,
    input logic                  tac_stop_o,
    input logic                  smp_req_o,
    input logic                  conv_req_o,
    input logic                  fifo_wr_o,
    input logic [ACQ_WORD_W-1:0] fifo_data_o,
    input logic                  busy_o,
    input logic [ACQ_EVT_W-1:0]  evt_cnt_o
);

    localparam logic [LVL_W-1:0] FULL_MARK = LVL_W'(FIFO_DEPTH);
    localparam logic [LVL_W-1:0] HALF_MARK = LVL_W'(FIFO_DEPTH / 2);

    AST_NO_ENABLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (trig_i && chan_en_i == '0) |=> (evt_cnt_o == $past(evt_cnt_o))); // R1

    AST_START_BEFORE_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (tac_start_o != '0) |-> (busy_o && !smp_req_o)); // R2

    AST_EVT_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (evt_cnt_o != $past(evt_cnt_o)) |-> (evt_cnt_o == $past(evt_cnt_o) + ACQ_EVT_W'(1))); // R3

    AST_BUSY_TRIG_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && trig_i) |=> (evt_cnt_o == $past(evt_cnt_o))); // R4

    AST_HDR_THEN_CONVERT: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr_o && fifo_data_o[ACQ_WORD_W-1]) |=> conv_req_o); // R6

    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_o |-> busy_o); // R7

    AST_NO_WRITE_SAMPLING: assert property (@(posedge clk) disable iff (rst)
        smp_req_o |-> (!fifo_wr_o && !conv_req_o)); // R8

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (fifo_full_mode_i && fifo_level_i >= FULL_MARK) |-> busy_o); // R9

    AST_HALF_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!fifo_full_mode_i && fifo_level_i > HALF_MARK) |-> busy_o); // R9

    AST_STOP_WITH_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        tac_stop_o |-> smp_req_o); // R10

endmodule

bind acq_sequencer acq_sequencer_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) i_chk (
    .clk              (clk),
    .rst              (rst),
    .trig_i           (trig_i),
    .chan_en_i        (chan_en_i),
    .fifo_full_mode_i (fifo_full_mode_i),
    .fifo_level_i     (fifo_level_i),
    .tac_start_o      (tac_start_o),
    .tac_stop_o       (tac_stop_o),
    .smp_req_o        (smp_req_o),
    .conv_req_o       (conv_req_o),
    .fifo_wr_o        (fifo_wr_o),
    .fifo_data_o      (fifo_data_o),
    .busy_o           (busy_o),
    .evt_cnt_o        (evt_cnt_o)
);

// File: tb/test_acq_sequencer.sv
`timescale 1ns/1ps
module test_acq_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic        mode_stop = 1'b0;
    logic [7:0]  chan_en = '0;
    logic [7:0]  thr_lo = '0;
    logic [7:0]  thr_hi = '0;
    logic [9:0]  full_scale = '0;
    logic        fifo_full_mode = 1'b0;
    logic [9:0]  fifo_level = '0;
    logic [7:0]  tac_start;
    logic        tac_stop;
    logic        smp_req;
    logic        smp_ack = 1'b0;
    logic [95:0] smp_data;
    logic        conv_req;
    logic [2:0]  conv_ch;
    logic        conv_ack = 1'b0;
    logic [11:0] conv_data = '0;
    logic        fifo_wr;
    logic [15:0] fifo_data;
    logic        busy;
    logic [11:0] evt_cnt;

    logic [11:0] smp [8];
    logic [15:0] got [16];
    int          nwr = 0;
    int          cyc = 0;
    int          last_wr_cyc = 0;
    int          checks = 0;
    int          errors = 0;
    logic [11:0] evt_exp = '0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) smp_data[i*12 +: 12] = smp[i];
    end

    acq_sequencer i_acq_sequencer (
        .clk(clk), .rst(rst), .trig_i(trig), .mode_stop_i(mode_stop),
        .chan_en_i(chan_en), .thr_lo_i(thr_lo), .thr_hi_i(thr_hi),
        .full_scale_i(full_scale), .fifo_full_mode_i(fifo_full_mode),
        .fifo_level_i(fifo_level), .tac_start_o(tac_start), .tac_stop_o(tac_stop),
        .smp_req_o(smp_req), .smp_ack_i(smp_ack), .smp_data_i(smp_data),
        .conv_req_o(conv_req), .conv_ch_o(conv_ch), .conv_ack_i(conv_ack),
        .conv_data_i(conv_data), .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data),
        .busy_o(busy), .evt_cnt_o(evt_cnt)
    );

    function automatic logic [11:0] conv_model(input logic [11:0] s);
        return s ^ 12'hA5A;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Front-end model: acknowledge sample and conversion requests after a short wait.
    initial begin
        int sw = 0;
        int cw = 0;
        forever begin
            @(negedge clk);
            if (smp_req && !smp_ack) begin
                if (sw == 1) begin smp_ack = 1'b1; sw = 0; end
                else sw++;
            end else begin
                smp_ack = 1'b0; sw = 0;
            end
            if (conv_req && !conv_ack) begin
                if (cw == 2) begin conv_ack = 1'b1; conv_data = conv_model(smp[conv_ch]); cw = 0; end
                else cw++;
            end else begin
                conv_ack = 1'b0; cw = 0;
            end
        end
    end

    // Write monitor.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            cyc++;
            if (fifo_wr === 1'b1) begin
                if (nwr < 16) got[nwr] = fifo_data;
                nwr++;
                last_wr_cyc = cyc;
            end
        end
    end

    task automatic run_event(input bit stop_m, input logic [7:0] en, input logic [7:0] lo,
                             input logic [7:0] hi, input int fs, input bit retrig);
        int n;
        int g;
        int fall_cyc;
        logic [7:0] hits;
        int cnt;
        int k;
        @(negedge clk);
        mode_stop = stop_m; chan_en = en; thr_lo = lo; thr_hi = hi;
        full_scale = 10'(fs); trig = 1'b1; nwr = 0;
        @(negedge clk);
        trig = 1'b0;
        #4;
        evt_exp = evt_exp + 12'd1;
        chk("R1", "busy after trigger", busy, 1);
        if (stop_m) chk("R10", "stop pulse", tac_stop, 1);
        else chk("R2", "start pulse mask", tac_start, en);
        n = 0;
        while (!smp_req && n < 2000) begin
            trig = (retrig && n == 3) ? 1'b1 : 1'b0;
            @(negedge clk); #4;
            n++;
        end
        trig = 1'b0;
        if (stop_m) chk("R10", "sample delay", n, 0);
        else chk("R2", "sample delay", n, fs + 1);
        g = 0;
        while (busy && g < 5000) begin @(negedge clk); #4; g++; end
        fall_cyc = cyc;
        hits = '0;
        for (int c = 0; c < 8; c++)
            if (en[c] && smp[c][11:4] >= lo && smp[c][11:4] <= hi) hits[c] = 1'b1;
        cnt = $countones(hits);
        chk(retrig ? "R4" : "R3", "event counter", evt_cnt, evt_exp);
        if (cnt == 0) begin
            chk("R8", "no words written", nwr, 0);
        end else begin
            chk("R5", "word count", nwr, cnt + 1);
            chk("R6", "header", got[0], {1'b1, evt_exp, 3'(cnt - 1)});
            k = 1;
            for (int c = 0; c < 8; c++) begin
                if (hits[c] && k < 16) begin
                    chk("R7", "data word", got[k], {1'b0, 3'(c), conv_model(smp[c])});
                    k++;
                end
            end
            chk("R12", "busy fall cycle", fall_cyc, last_wr_cyc + 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] ub [8];
        logic [7:0] los [3];
        logic [7:0] his [3];
        for (int c = 0; c < 8; c++) smp[c] = '0;
        repeat (3) @(negedge clk);
        #4;
        chk("R11", "reset busy", busy, 0);
        chk("R11", "reset counter", evt_cnt, 0);
        chk("R11", "reset write", fifo_wr, 0);
        chk("R11", "reset sample req", smp_req, 0);
        @(negedge clk); rst = 1'b0;

        // R1: no channel enabled, trigger ignored
        trig = 1'b1; chan_en = '0;
        @(negedge clk); trig = 1'b0; #4;
        chk("R1", "busy with no enable", busy, 0);
        chk("R1", "counter with no enable", evt_cnt, 0);

        // Exhaustive enable sweep, boundary samples around lo=40 hi=200
        ub = '{8'd39, 8'd40, 8'd41, 8'd120, 8'd199, 8'd200, 8'd201, 8'd255};
        for (int c = 0; c < 8; c++) smp[c] = {ub[c], 4'(c)};
        for (int e = 1; e < 256; e++) run_event(1'b1, 8'(e), 8'd40, 8'd200, 0, 1'b0);

        // Common-start with several full-scale values
        run_event(1'b0, 8'hFF, 8'd40, 8'd200, 0, 1'b0);
        run_event(1'b0, 8'h5A, 8'd40, 8'd200, 1, 1'b0);
        run_event(1'b0, 8'hA5, 8'd40, 8'd200, 17, 1'b0);
        // R4: retrigger while busy
        run_event(1'b0, 8'hFF, 8'd40, 8'd200, 12, 1'b1);

        // Window sweep with rotated samples, including lo>hi (R8)
        for (int c = 0; c < 8; c++) smp[c] = {8'(c * 37), 4'hF};
        los = '{8'd0, 8'd74, 8'd255};
        his = '{8'd0, 8'd148, 8'd255};
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                run_event(1'b0, 8'hFF, los[a], his[b], 3, 1'b0);

        // R9: FIFO blocking
        @(negedge clk);
        fifo_full_mode = 1'b0; fifo_level = 10'd257; #4;
        chk("R9", "half mode 257 blocks", busy, 1);
        @(negedge clk); trig = 1'b1; chan_en = 8'hFF;
        @(negedge clk); trig = 1'b0; #4;
        chk("R9", "blocked trigger ignored", evt_cnt, evt_exp);
        fifo_level = 10'd256; #1;
        chk("R9", "half mode 256 free", busy, 0);
        fifo_full_mode = 1'b1; fifo_level = 10'd511; #1;
        chk("R9", "full mode 511 free", busy, 0);
        fifo_level = 10'd512; #1;
        chk("R9", "full mode 512 blocks", busy, 1);
        fifo_level = '0; fifo_full_mode = 1'b0;

        // R3: wrap of the event counter
        for (int c = 0; c < 8; c++) smp[c] = 12'hFFF;
        while (evt_exp != 12'hFFF) run_event(1'b1, 8'h01, 8'd0, 8'd0, 0, 1'b0);
        for (int c = 0; c < 8; c++) smp[c] = {8'(c + 1), 4'h3};
        run_event(1'b1, 8'h24, 8'd0, 8'd255, 0, 1'b0);
        chk("R3", "counter wrapped", evt_cnt, 0);

        // R11: reset in the middle of an event
        @(negedge clk);
        mode_stop = 1'b0; full_scale = 10'd50; chan_en = 8'h0F; trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #4;
        chk("R11", "mid-event reset busy", busy, 0);
        chk("R11", "mid-event reset counter", evt_cnt, 0);
        chk("R11", "mid-event reset sample req", smp_req, 0);
        @(negedge clk); rst = 1'b0; evt_exp = '0;
        for (int c = 0; c < 8; c++) smp[c] = {8'd100, 4'(c)};
        run_event(1'b1, 8'h81, 8'd100, 8'd100, 0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule